// File: doc/BRIEF.md
# Programmable Oversampling Baud Tick Generator

This block sets the bit timing for a serial transmitter and receiver. A clock enable from an upstream prescaler is divided by a 16-bit divisor. The divisor is assembled from two byte registers. Each time the divisor count completes, the block issues a sample strobe for the receiver. A second counter counts these sample strobes, and its length is the oversampling ratio, which can be anything from 4 to 16 samples per bit. When that counter wraps, the block issues a one-per-bit strobe for the transmitter.

Software loads the two divisor bytes and the oversampling code through a byte-wide write port. The resulting bit rate is the clock frequency divided by (samples per bit × divisor × prescale factor). As an example, take a 1.8432 MHz clock with the prescale set to 1 and 16x sampling. A divisor of 12 then gives 9600 bit/s, and a divisor of 1 gives 115200 bit/s, which is one sixteenth of the clock. Any write to a register restarts both counters from the new settings, so each new rate starts on a clean bit boundary.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both strobes are low, the oversampling code is 0, the divisor is 1, and the block runs at 16 samples per bit with one sample strobe per enable pulse.
- R2: The divisor is low byte + 256 × high byte. A sample strobe occurs once every divisor enable pulses, so with a divisor of 12 and 16x sampling a bit lasts 192 enable pulses.
- R3: A divisor of 0 behaves exactly like a divisor of 1.
- R4: Oversampling codes 4 to 15 give that many sample strobes per bit, and code 0 gives 16.
- R5: Oversampling codes 1, 2 and 3 are out of range and give 16 samples per bit.
- R6: The bit strobe is high for exactly one clock and always coincides with the sample strobe that ends the bit.
- R7: A strobe rises only in the clock after an enabled cycle. With an enable pulse every P clocks, a bit lasts samples × divisor × P clocks.
- R8: Writes to address 0, 1 or 2 schedule a restart. The first enable pulse after the write clears both counters and emits no strobe. The first sample strobe then follows after divisor enable pulses, and the first bit strobe after samples × divisor enable pulses.
- R9: Address 0 writes the divisor low byte, address 1 writes the high byte, and address 2 writes the oversampling code from data bits 3:0. A write to address 3 changes nothing and does not disturb the strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Enable pulse from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| sample_tick | output | 1 | One-clock strobe per sample |
| bit_tick | output | 1 | One-clock strobe per bit |

## Verification
Both strobes are registered. Each one rises in the clock after the enabled edge that completes its count, so a strobe never appears in the same cycle as the enable pulse that caused it.

For period checks, the bench settles on one full bit and then measures the next one, counting clocks and sample strobes between two bit strobes. The expected length is samples × divisor × enable spacing.

For restart timing, the bench counts edges from the edge that captures the write. The restart falls on the next enabled edge, the first sample strobe is due divisor edges after that, and the first bit strobe samples × divisor edges after the restart. The bench samples each of these at the falling edge that follows.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int BYTE_W = 8,
  parameter int OVS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int SPB_W = OVS_W + 1;
  localparam logic [SPB_W-1:0] SPB_MAX_LAST = SPB_W'((1 << OVS_W) - 1);
  localparam logic [OVS_W-1:0] OVS_MIN = OVS_W'(4);

  logic [BYTE_W-1:0] div_lo, div_hi;
  logic [OVS_W-1:0]  ovs;
  logic              pend;
  logic [DIV_W-1:0]  div_cnt;
  logic [SPB_W-1:0]  smp_cnt;

  wire [DIV_W-1:0] div_raw  = {div_hi, div_lo};
  wire [DIV_W-1:0] div_last = (div_raw == '0) ? '0 : div_raw - 1'b1;
  wire [SPB_W-1:0] spb_last = (ovs < OVS_MIN) ? SPB_MAX_LAST : {1'b0, ovs} - 1'b1;
  wire             div_wrap = div_cnt >= div_last;
  wire             smp_wrap = smp_cnt >= spb_last;
  wire             cfg_wr   = wr_en && (wr_addr != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo <= BYTE_W'(1);
      div_hi <= '0;
      ovs    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    div_lo <= wr_data;
        2'd1:    div_hi <= wr_data;
        2'd2:    ovs    <= wr_data[OVS_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (cfg_wr)
      pend <= 1'b1;
    else if (clk_en)
      pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt     <= '0;
      smp_cnt     <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
      if (clk_en) begin
        if (pend) begin
          div_cnt <= '0;
          smp_cnt <= '0;
        end else if (div_wrap) begin
          div_cnt     <= '0;
          sample_tick <= 1'b1;
          if (smp_wrap) begin
            smp_cnt  <= '0;
            bit_tick <= 1'b1;
          end else begin
            smp_cnt <= smp_cnt + 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_en,
  input logic sample_tick,
  input logic bit_tick,
  input logic pend
);
  logic [4:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run <= '0;
    else if (bit_tick || (pend && clk_en))
      run <= '0;
    else if (sample_tick)
      run <= run + 1'b1;
  end

  // R6
  bit_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  // R6
  bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  // R7
  tick_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_tick) |-> $past(clk_en));

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && clk_en) |=> (!sample_tick && !bit_tick));

  // R4
  spb_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 5'd15);
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
  .sample_tick(sample_tick), .bit_tick(bit_tick), .pend(pend)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sample_tick, bit_tick;

  int checks = 0;
  int errors = 0;
  int en_per = 1;
  int en_ctr = 0;
  bit done = 1'b0;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    clk_en <= (en_ctr == 0);
    en_ctr <= (en_ctr + 1 >= en_per) ? 0 : en_ctr + 1;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic align();
    int g = 0;
    @(negedge clk);
    while (!bit_tick && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic measure(output int bp, output int ns);
    bp = 0; ns = 0;
    align();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      bp++;
      if (sample_tick) ns++;
      if (bit_tick) break;
    end
  endtask

  task automatic settle_measure(output int bp, output int ns);
    int b0, n0;
    measure(b0, n0);
    measure(bp, ns);
  endtask

  task automatic t_reset();
    int bp, ns;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sample_tick in reset", int'(sample_tick), 0);
    check("R1 bit_tick in reset", int'(bit_tick), 0);
    rst_n = 1'b1;
    settle_measure(bp, ns);
    check("R1 default bit period", bp, 16);
    check("R1 default samples per bit", ns, 16);
  endtask

  task automatic t_div12();
    int bp, ns;
    wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'd12);
    settle_measure(bp, ns);
    check("R2 divisor 12 bit period", bp, 192);
    check("R2 divisor 12 samples", ns, 16);
  endtask

  task automatic t_high();
    int bp, ns;
    wr(2'd0, 8'h00); wr(2'd1, 8'h01); wr(2'd2, 8'h04);
    settle_measure(bp, ns);
    check("R2 high byte divisor 256 period", bp, 1024);
    check("R9 code at address 2 samples", ns, 4);
  endtask

  task automatic t_ovs();
    int bp, ns;
    wr(2'd1, 8'h00); wr(2'd0, 8'd3);
    wr(2'd2, 8'h09);
    settle_measure(bp, ns);
    check("R4 code 9 period", bp, 27);
    check("R4 code 9 samples", ns, 9);
    wr(2'd2, 8'hFF);
    settle_measure(bp, ns);
    check("R4 code 15 period (upper bits ignored)", bp, 45);
    wr(2'd2, 8'h00);
    settle_measure(bp, ns);
    check("R4 code 0 period", bp, 48);
    check("R4 code 0 samples", ns, 16);
  endtask

  task automatic t_illegal();
    int bp, ns;
    wr(2'd0, 8'd2);
    for (int c = 1; c <= 3; c++) begin
      wr(2'd2, 8'(c));
      settle_measure(bp, ns);
      check("R5 low code period", bp, 32);
      check("R5 low code samples", ns, 16);
    end
  endtask

  task automatic t_div0();
    int bp, ns;
    wr(2'd2, 8'h04); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    settle_measure(bp, ns);
    check("R3 divisor zero period", bp, 4);
    check("R3 divisor zero samples", ns, 4);
  endtask

  task automatic t_align();
    align();
    check("R6 bit with sample", int'(sample_tick), 1);
    @(negedge clk);
    check("R6 bit one clock", int'(bit_tick), 0);
  endtask

  task automatic t_enable();
    int bp, ns;
    wr(2'd0, 8'd2); wr(2'd2, 8'h05);
    en_per = 3;
    settle_measure(bp, ns);
    check("R7 enable every 3 period", bp, 30);
    check("R7 enable every 3 samples", ns, 5);
    en_per = 1;
  endtask

  task automatic t_addr3();
    int bp, ns, k;
    wr(2'd0, 8'd2); wr(2'd2, 8'h04);
    settle_measure(bp, ns);
    align();
    k = 1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'hFF;
    @(negedge clk); k++;
    wr_en = 1'b0;
    while (!bit_tick && k < 100) begin @(negedge clk); k++; end
    check("R9 address 3 keeps phase", k, 8);
    settle_measure(bp, ns);
    check("R9 address 3 keeps period", bp, 8);
  endtask

  task automatic t_reload();
    int bp, ns, fs, fb;
    wr(2'd0, 8'd5); wr(2'd2, 8'h04);
    settle_measure(bp, ns);
    fs = 0; fb = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd2;
    @(negedge clk);
    wr_en = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (sample_tick && fs == 0) fs = k;
      if (bit_tick && fb == 0) fb = k;
    end
    check("R8 first sample after restart", fs, 3);
    check("R8 first bit after restart", fb, 9);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_div12();
    t_high();
    t_ovs();
    t_illegal();
    t_div0();
    t_align();
    t_enable();
    t_addr3();
    t_reload();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule